// File: doc/BRIEF.md
# Indirect Jump Resolve and Misaligned-Target Trap Unit

This block sits in the execute stage of a 64-bit core. It resolves a register-indirect jump, where the target is a base register plus an immediate. It decides whether that target is a legal fetch address. Each jump is offered for one cycle with a valid strobe. The block adds the base and the immediate, forces bit 0 of the sum to zero, and then checks bit 1 of the result against the alignment the core currently requires.

When 16-bit instructions are enabled, a 2-byte aligned target is accepted. When they are disabled, bit 1 must also be zero. A legal jump steers fetch to the target and writes the return address to its destination register. An illegal jump does neither: it raises a trap request that carries the misaligned-fetch cause code and the address of the jump itself.

All outputs are registered. They appear one clock after the jump is presented. Trap vectoring, the control and status registers and privilege handling belong to the surrounding control logic.

Top module: `jalr_align_trap_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is driven to zero in the following cycle.
- R2: One cycle after a jump is accepted (`jmp_valid_i` high), the fetch target is `(base_i + imm_i)` with bit 0 forced to 0, so an odd sum alone never traps; `redirect_valid_o` is 1 and `redirect_pc_o` carries that target whenever no trap is raised.
- R3: With `compressed_en_i` = 0, a target whose bit 1 is 1 (after bit 0 is cleared, e.g. a 4-byte aligned base plus offset 2 or 3) gives `trap_valid_o` = 1 for exactly that one cycle; `redirect_valid_o` is 0 and `redirect_pc_o` is 0.
- R4: With `compressed_en_i` = 1, a target with bit 1 set is legal: no trap, and the redirect is issued.
- R5: A trapping jump never writes back: `wb_en_o`, `wb_idx_o` and `wb_data_o` are all 0 in the trap cycle.
- R6: `trap_cause_o` is the 64-bit value 0, the instruction-address-misaligned code, and is 0 whenever no trap is raised.
- R7: On a trap, `trap_epc_o` equals the jump's own `jmp_pc_i`, not the target; it is 0 when no trap is raised.
- R8: A non-trapping jump with a nonzero `rd_idx_i` gives `wb_en_o` = 1, `wb_idx_o` = `rd_idx_i` and `wb_data_o` = `jmp_pc_i + 4`.
- R9: A jump with `rd_idx_i` = 0 never writes back: `wb_en_o`, `wb_idx_o` and `wb_data_o` are 0, while the redirect or trap still happens.
- R10: One cycle after `jmp_valid_i` is low, every output is 0, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| jmp_valid_i | input | 1 | A jump is presented this cycle |
| jmp_pc_i | input | 64 | Address of the jump instruction |
| base_i | input | 64 | Base register value |
| imm_i | input | 64 | Sign-extended immediate |
| rd_idx_i | input | 5 | Destination register index |
| compressed_en_i | input | 1 | 16-bit instructions enabled |
| redirect_valid_o | output | 1 | Steer fetch to `redirect_pc_o` |
| redirect_pc_o | output | 64 | Resolved jump target |
| wb_en_o | output | 1 | Write the link value |
| wb_idx_o | output | 5 | Register written |
| wb_data_o | output | 64 | Link value (jump PC + 4) |
| trap_valid_o | output | 1 | Misaligned-target trap request |
| trap_cause_o | output | 64 | Trap cause code |
| trap_epc_o | output | 64 | Exception PC (the jump's address) |

## Verification
Two decisions fall in the same cycle: the alignment verdict and the link-register write. A trap must cancel a write that would otherwise go to a nonzero register. The bench provokes this by presenting jumps that carry a nonzero destination together with targets that have bit 1 set, and it toggles the compressed-enable flag between such jumps, including back to back. A reference model computed from integer arithmetic judges every cycle: the write-back, the redirect and the trap fields must agree with it, and at most one of write-back and trap may be active.

// File: rtl/jtu_pkg.sv
// Shared definitions for the indirect jump resolve unit.
// Assumes: cause codes fit in the low bits of a 64-bit cause word.
package jtu_pkg;

    // Cause code for an instruction fetch address that is not aligned
    localparam int unsigned CAUSE_FETCH_MISALIGNED = 0;

    // Per-jump decision flags passed from the gate to the output register
    typedef struct packed {
        logic redirect;
        logic writeback;
        logic trap;
    } jtu_flags_t;

endpackage

// File: rtl/jtu_target_calc.sv
// Computes the jump target and the link value for an indirect jump.
// Assumes: the immediate is already sign-extended to XLEN bits; the sum wraps.
module jtu_target_calc #(
    parameter int XLEN        = 64,
    parameter int LINK_OFFSET = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] target_o,
    output logic [XLEN-1:0] link_o
);

    localparam logic [XLEN-1:0] LINK_INC = XLEN'(LINK_OFFSET);

    logic [XLEN-1:0] raw_sum;

    // Add base and offset, then drop bit 0 so an odd sum is never a fault
    always_comb begin
        raw_sum  = base_i + imm_i;
        target_o = {raw_sum[XLEN-1:1], 1'b0};
    end

    // Return address is the instruction after the jump
    always_comb begin
        link_o = pc_i + LINK_INC;
    end

endmodule

// File: rtl/jtu_align_check.sv
// Decides whether a cleared-LSB target is a legal fetch address.
// Assumes: bit 0 of the target is already zero; HAS_COMPRESSED selects
// whether the runtime compressed-enable flag can relax the rule.
module jtu_align_check #(
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic tgt_bit1_i,
    input  logic c_en_i,
    output logic misaligned_o
);

    generate
        if (HAS_COMPRESSED) begin : g_relaxable
            // Half-word targets are legal only while compressed code is enabled
            always_comb begin
                misaligned_o = tgt_bit1_i & ~c_en_i;
            end
        end else begin : g_strict
            logic unused_c_en;
            // Without compressed support every target must be word aligned
            always_comb begin
                unused_c_en  = c_en_i;
                misaligned_o = tgt_bit1_i;
            end
        end
    endgenerate

endmodule

// File: rtl/jtu_commit_gate.sv
// Turns a resolved jump and its alignment verdict into the next-cycle values
// of the redirect, write-back and trap fields; inactive fields are zeroed.
// Assumes: register index 0 is hard-wired to zero and must never be written.
module jtu_commit_gate
    import jtu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5
) (
    input  logic              valid_i,
    input  logic              misaligned_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   target_i,
    input  logic [XLEN-1:0]   link_i,
    input  logic [RIDX_W-1:0] rd_i,
    output jtu_flags_t        flags_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [RIDX_W-1:0] wb_idx_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o
);

    localparam logic [XLEN-1:0] CAUSE_WORD = XLEN'(CAUSE_FETCH_MISALIGNED);

    logic rd_nonzero;

    // Decide which of the three actions the jump takes
    always_comb begin
        rd_nonzero        = |rd_i;
        flags_o.trap      = valid_i & misaligned_i;
        flags_o.redirect  = valid_i & ~misaligned_i;
        flags_o.writeback = valid_i & ~misaligned_i & rd_nonzero;
    end

    // Zero every data field whose action is not taken
    always_comb begin
        redirect_pc_o = flags_o.redirect  ? target_i   : '0;
        wb_idx_o      = flags_o.writeback ? rd_i       : '0;
        wb_data_o     = flags_o.writeback ? link_i     : '0;
        cause_o       = flags_o.trap      ? CAUSE_WORD : '0;
        epc_o         = flags_o.trap      ? pc_i       : '0;
    end

endmodule

// File: rtl/jalr_align_trap_unit.sv
// Top of the indirect jump resolve unit: computes the target, checks it
// against the active alignment rule, and registers redirect, write-back and
// trap outputs one cycle after the jump is presented.
// Assumes: one jump per cycle at most; synchronous active-low reset.
module jalr_align_trap_unit
    import jtu_pkg::*;
#(
    parameter int XLEN           = 64,
    parameter int RIDX_W         = 5,
    parameter int LINK_OFFSET    = 4,
    parameter bit HAS_COMPRESSED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jmp_valid_i,
    input  logic [XLEN-1:0]   jmp_pc_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   imm_i,
    input  logic [RIDX_W-1:0] rd_idx_i,
    input  logic              compressed_en_i,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic              wb_en_o,
    output logic [RIDX_W-1:0] wb_idx_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic              trap_valid_o,
    output logic [XLEN-1:0]   trap_cause_o,
    output logic [XLEN-1:0]   trap_epc_o
);

    logic [XLEN-1:0]   target;
    logic [XLEN-1:0]   link;
    logic              misaligned;
    jtu_flags_t        nxt_flags;
    logic [XLEN-1:0]   nxt_rpc;
    logic [RIDX_W-1:0] nxt_widx;
    logic [XLEN-1:0]   nxt_wdata;
    logic [XLEN-1:0]   nxt_cause;
    logic [XLEN-1:0]   nxt_epc;

    jtu_target_calc #(
        .XLEN        (XLEN),
        .LINK_OFFSET (LINK_OFFSET)
    ) u_calc (
        .pc_i     (jmp_pc_i),
        .base_i   (base_i),
        .imm_i    (imm_i),
        .target_o (target),
        .link_o   (link)
    );

    jtu_align_check #(
        .HAS_COMPRESSED (HAS_COMPRESSED)
    ) u_align (
        .tgt_bit1_i   (target[1]),
        .c_en_i       (compressed_en_i),
        .misaligned_o (misaligned)
    );

    jtu_commit_gate #(
        .XLEN   (XLEN),
        .RIDX_W (RIDX_W)
    ) u_gate (
        .valid_i       (jmp_valid_i),
        .misaligned_i  (misaligned),
        .pc_i          (jmp_pc_i),
        .target_i      (target),
        .link_i        (link),
        .rd_i          (rd_idx_i),
        .flags_o       (nxt_flags),
        .redirect_pc_o (nxt_rpc),
        .wb_idx_o      (nxt_widx),
        .wb_data_o     (nxt_wdata),
        .cause_o       (nxt_cause),
        .epc_o         (nxt_epc)
    );

    // Register every output; reset clears them all
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid_o <= 1'b0;
            redirect_pc_o    <= '0;
            wb_en_o          <= 1'b0;
            wb_idx_o         <= '0;
            wb_data_o        <= '0;
            trap_valid_o     <= 1'b0;
            trap_cause_o     <= '0;
            trap_epc_o       <= '0;
        end else begin
            redirect_valid_o <= nxt_flags.redirect;
            redirect_pc_o    <= nxt_rpc;
            wb_en_o          <= nxt_flags.writeback;
            wb_idx_o         <= nxt_widx;
            wb_data_o        <= nxt_wdata;
            trap_valid_o     <= nxt_flags.trap;
            trap_cause_o     <= nxt_cause;
            trap_epc_o       <= nxt_epc;
        end
    end

endmodule

// File: rtl/jalr_align_trap_unit_chk.sv
// Property checker for the indirect jump resolve unit, attached by bind.
// Assumes: outputs follow the inputs sampled at the previous rising edge.
module jalr_align_trap_unit_chk #(
    parameter int XLEN   = 64,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jmp_valid_i,
    input  logic [XLEN-1:0]   jmp_pc_i,
    input  logic [RIDX_W-1:0] rd_idx_i,
    input  logic              compressed_en_i,
    input  logic              redirect_valid_o,
    input  logic [XLEN-1:0]   redirect_pc_o,
    input  logic              wb_en_o,
    input  logic [XLEN-1:0]   wb_data_o,
    input  logic              trap_valid_o,
    input  logic [XLEN-1:0]   trap_cause_o,
    input  logic [XLEN-1:0]   trap_epc_o
);

    // R2: a redirect target never has bit 0 set
    assert_even_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> !redirect_pc_o[0]);

    // R3: a trap and a redirect are never issued together
    assert_trap_no_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> !redirect_valid_o);

    // R4: with compressed code enabled, no jump traps
    assert_compressed_no_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid_i && compressed_en_i) |=> !trap_valid_o);

    // R5: a trapping jump writes no register
    assert_trap_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> !wb_en_o);

    // R6: the trap carries the misaligned-fetch cause
    assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> (trap_cause_o == '0));

    // R7: the exception PC is the jump's own address
    assert_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> (trap_epc_o == $past(jmp_pc_i)));

    // R8: the link value is the jump address plus one instruction
    assert_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_data_o == $past(jmp_pc_i) + XLEN'(4)));

    // R9: register index 0 is never written
    assert_rd0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid_i && rd_idx_i == '0) |=> !wb_en_o);

    // R10: no jump presented means no action next cycle
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !jmp_valid_i |=> (!wb_en_o && !redirect_valid_o && !trap_valid_o));

endmodule

bind jalr_align_trap_unit jalr_align_trap_unit_chk #(
    .XLEN   (XLEN),
    .RIDX_W (RIDX_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .jmp_valid_i      (jmp_valid_i),
    .jmp_pc_i         (jmp_pc_i),
    .rd_idx_i         (rd_idx_i),
    .compressed_en_i  (compressed_en_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .wb_en_o          (wb_en_o),
    .wb_data_o        (wb_data_o),
    .trap_valid_o     (trap_valid_o),
    .trap_cause_o     (trap_cause_o),
    .trap_epc_o       (trap_epc_o)
);

// File: tb/jalr_align_trap_unit_bench.sv
// Bench: drives jumps on the falling edge, keeps a behavioural model of the
// expected registered outputs, and compares every field on the next falling edge.
module jalr_align_trap_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        jmp_valid_i;
    logic [63:0] jmp_pc_i;
    logic [63:0] base_i;
    logic [63:0] imm_i;
    logic [4:0]  rd_idx_i;
    logic        compressed_en_i;
    logic        redirect_valid_o;
    logic [63:0] redirect_pc_o;
    logic        wb_en_o;
    logic [4:0]  wb_idx_o;
    logic [63:0] wb_data_o;
    logic        trap_valid_o;
    logic [63:0] trap_cause_o;
    logic [63:0] trap_epc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Expected outputs for the cycle after the currently applied inputs
    bit          e_rv;
    logic [63:0] e_rpc;
    bit          e_wb;
    logic [4:0]  e_widx;
    logic [63:0] e_wdata;
    bit          e_trap;
    logic [63:0] e_cause;
    logic [63:0] e_epc;
    string       e_ctx;

    always #5 clk = ~clk;

    jalr_align_trap_unit u_jalr_align_trap_unit (
        .clk              (clk),
        .rst_n            (rst_n),
        .jmp_valid_i      (jmp_valid_i),
        .jmp_pc_i         (jmp_pc_i),
        .base_i           (base_i),
        .imm_i            (imm_i),
        .rd_idx_i         (rd_idx_i),
        .compressed_en_i  (compressed_en_i),
        .redirect_valid_o (redirect_valid_o),
        .redirect_pc_o    (redirect_pc_o),
        .wb_en_o          (wb_en_o),
        .wb_idx_o         (wb_idx_o),
        .wb_data_o        (wb_data_o),
        .trap_valid_o     (trap_valid_o),
        .trap_cause_o     (trap_cause_o),
        .trap_epc_o       (trap_epc_o)
    );

    task automatic cmp(input string tag, input string field,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, field, act, exp);
        end
    endtask

    function automatic string pick(input string dflt);
        return (e_ctx != "") ? e_ctx : dflt;
    endfunction

    // Compare all outputs with the model, then apply new inputs and predict
    task automatic step(input bit r, input bit v, input logic [63:0] pc,
                        input logic [63:0] b, input logic [63:0] im,
                        input logic [4:0] rd, input bit c);
        logic [63:0] sum;
        logic [63:0] tgt;
        bit          bad;
        cmp(pick("R2"), "redirect_valid", {63'd0, redirect_valid_o}, {63'd0, e_rv});
        cmp(pick("R2"), "redirect_pc", redirect_pc_o, e_rpc);
        cmp(pick("R3"), "trap_valid", {63'd0, trap_valid_o}, {63'd0, e_trap});
        cmp(pick("R6"), "trap_cause", trap_cause_o, e_cause);
        cmp(pick("R7"), "trap_epc", trap_epc_o, e_epc);
        cmp(pick("R5"), "wb_en", {63'd0, wb_en_o}, {63'd0, e_wb});
        cmp(pick("R8"), "wb_idx", {59'd0, wb_idx_o}, {59'd0, e_widx});
        cmp(pick("R8"), "wb_data", wb_data_o, e_wdata);
        rst_n = r; jmp_valid_i = v; jmp_pc_i = pc; base_i = b;
        imm_i = im; rd_idx_i = rd; compressed_en_i = c;
        sum = b + im;
        tgt = sum - (sum % 2);
        bad = (c == 1'b0) && ((tgt / 2) % 2 == 1);
        e_rv = 0; e_rpc = 0; e_wb = 0; e_widx = 0; e_wdata = 0;
        e_trap = 0; e_cause = 0; e_epc = 0; e_ctx = "";
        if (!r) begin
            e_ctx = "R1";
        end else if (!v) begin
            e_ctx = "R10";
        end else begin
            if (bad) begin
                e_trap = 1; e_epc = pc;
                e_ctx = (rd != 0) ? "R5" : "R3";
            end else begin
                e_rv = 1; e_rpc = tgt;
                if (rd != 0) begin
                    e_wb = 1; e_widx = rd; e_wdata = pc + 64'd4;
                end
                if (c && ((tgt / 2) % 2 == 1)) e_ctx = "R4";
            end
            if (rd == 0 && e_ctx == "") e_ctx = "R9";
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; jmp_valid_i = 0; jmp_pc_i = 0; base_i = 0; imm_i = 0;
        rd_idx_i = 0; compressed_en_i = 0;
        e_rv = 0; e_rpc = 0; e_wb = 0; e_widx = 0; e_wdata = 0;
        e_trap = 0; e_cause = 0; e_epc = 0; e_ctx = "R1";
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, with a jump offered during reset
        step(0, 1, 64'h1000, 64'h2000, 64'd2, 5'd1, 0);
        step(0, 1, 64'h1000, 64'h2000, 64'd0, 5'd1, 0);
        // R2/R8: aligned target, link written
        step(1, 1, 64'h8000_0000, 64'h8000_0100, 64'd0, 5'd1, 0);
        // R2: odd sum loses bit 0 and does not trap
        step(1, 1, 64'h8000_0004, 64'h8000_0200, 64'd1, 5'd5, 0);
        // R3/R5/R7: offset 2 traps with compressed disabled, rd nonzero
        step(1, 1, 64'h8000_0008, 64'h8000_0300, 64'd2, 5'd6, 0);
        // R3: offset 3 traps too, back to back
        step(1, 1, 64'h8000_000c, 64'h8000_0300, 64'd3, 5'd6, 0);
        // R4: same offsets legal with compressed enabled
        step(1, 1, 64'h8000_0010, 64'h8000_0300, 64'd2, 5'd7, 1);
        step(1, 1, 64'h8000_0014, 64'h8000_0300, 64'd3, 5'd7, 1);
        // R3 then R4 toggle in successive cycles
        step(1, 1, 64'h8000_0018, 64'h8000_0402, 64'd0, 5'd9, 0);
        step(1, 1, 64'h8000_001c, 64'h8000_0402, 64'd0, 5'd9, 1);
        // R9: rd 0 with legal and trapping targets
        step(1, 1, 64'h8000_0020, 64'h8000_0500, 64'd4, 5'd0, 0);
        step(1, 1, 64'h8000_0024, 64'h8000_0500, 64'd6, 5'd0, 0);
        // Negative immediate and address wrap
        step(1, 1, 64'h8000_0028, 64'h8000_0500, -64'sd8, 5'd31, 0);
        step(1, 1, 64'hffff_ffff_ffff_fffc, 64'hffff_ffff_ffff_fff0, 64'h20, 5'd3, 0);
        // R10: idle cycles with garbage on the other inputs
        step(1, 0, 64'hdead_beef, 64'h3, 64'd3, 5'd4, 0);
        step(1, 0, 64'h1234_5678, 64'h2, 64'd0, 5'd8, 1);
        // R1: reset in the middle of traffic
        step(0, 1, 64'h40, 64'h42, 64'd0, 5'd2, 0);
        step(1, 1, 64'h44, 64'h42, 64'd0, 5'd2, 0);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            step(1, ($urandom % 4) != 0,
                 {$urandom, $urandom} & ~64'h3, {$urandom, $urandom},
                 {{32{1'b0}}, $urandom} - 64'h8000_0000,
                 5'($urandom), 1'($urandom));
        end
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule